// File: doc/BRIEF.md
# IP Header and Payload Length Checker

This block watches an outgoing Ethernet frame one byte per cycle over a valid/last stream. It does not change the data. It reads the EtherType and the IP header as they go past. When a frame ends, it reports two flags: one for a malformed IP header and one for a payload length that disagrees with the header. No checksum is computed. Instead the header fields are checked against each other and against the number of bytes that actually arrived.

Frames are taken without VLAN tags, IPv6 extension headers, Ethernet padding or FCS. So every byte after the IP header counts as transport payload. Only TCP, UDP and ICMP traffic is judged. Every other frame ends with both flags clear. A summary output is the OR of the two flags. It feeds a wider error summary elsewhere in the transmit path.

Top module: `ipchk_top`

## Requirements
- R1: After reset, `sts_valid_o`, `hdr_err_o`, `pay_err_o` and `err_sum_o` are all 0.
- R2: The EtherType is bytes 12 (high) and 13 (low), with byte 0 the first byte. A frame with an EtherType other than 0x0800 (IPv4) or 0x86DD (IPv6) ends with both flags 0. The same holds for a frame shorter than 14 bytes.
- R3: The IP version is the upper nibble of byte 14. An IP EtherType whose frame has no byte 14 raises the header flag. So does a version other than 4 under 0x0800, or other than 6 under 0x86DD.
- R4: For IPv4, a header length value (lower nibble of byte 14) below 5 raises the header flag.
- R5: A frame that ends before its IP header is complete raises the header flag. The header ends at byte 14+4×IHL for IPv4 and at byte 54 for IPv6. In that case the payload flag stays 0.
- R6: For IPv4, a total length (bytes 16–17, big-endian) smaller than 4×IHL raises the header flag.
- R7: A complete IP header whose protocol is not supported ends with both flags 0. The protocol is byte 23 for IPv4 and byte 20 for IPv6. Supported values are 1, 6 and 17 for IPv4, and 6, 17 and 58 for IPv6.
- R8: For a supported, well-formed header, the payload flag is 1 exactly when the byte count after the header differs from the expected length. The expected length is total length − 4×IHL for IPv4, and the field at bytes 18–19 for IPv6.
- R9: The two flags are never 1 together, and `err_sum_o` is their OR.
- R10: The status strobe and flags are registered and appear in the cycle after the last byte. They hold until the first byte of the next frame is accepted. They then read 0 until that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte on `data_i` is valid this cycle |
| data_i | input | 8 | Frame byte |
| last_i | input | 1 | Byte is the final one of the frame |
| sts_valid_o | output | 1 | Verdict for the last frame is present |
| hdr_err_o | output | 1 | IP header error |
| pay_err_o | output | 1 | IP payload length error |
| err_sum_o | output | 1 | OR of the error flags |

## Verification
Random IPv4, IPv6 and foreign-EtherType frames are sent with random IHL, protocol, length field and truncation point, and with idle gaps inside frames. These separate the header-flag paths from the payload-count path. Directed frames then hit each boundary on its own. These include a length field off by one in each direction, IHL exactly 4 and 5, a frame cut one byte short of its header end, a wrong version, ICMP under each IP version, and frames too short to carry an EtherType. They show which rule fires, and that a rule which should stay silent does. The same streams check that a verdict holds through idle cycles and drops when the next frame starts.

// File: rtl/ipchk_pkg.sv
package ipchk_pkg;
  localparam logic [15:0] ETYPE_V4 = 16'h0800;
  localparam logic [15:0] ETYPE_V6 = 16'h86DD;
  localparam int unsigned ETH_HDR_B = 14;
  localparam int unsigned V6_HDR_B  = 40;

  typedef struct packed {
    logic [15:0] etype;
    logic [3:0]  ver;
    logic [3:0]  ihl;
    logic [15:0] len_fld;  // v4 total length or v6 payload length
    logic [7:0]  proto;
  } ip_fields_t;
endpackage

// File: rtl/ipchk_byte_cnt.sv
module ipchk_byte_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  output logic [CNT_W-1:0] cnt_o
);
  // index of the byte currently on the bus, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (valid_i && last_i)    cnt_o <= '0;
    else if (valid_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end

  a_r10_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_i |=> cnt_o == '0);
  a_r10_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_o));
endmodule

// File: rtl/ipchk_field_cap.sv
module ipchk_field_cap
  import ipchk_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ip_fields_t       fld_o   // includes the byte on the bus this cycle
);
  ip_fields_t fld_q, fld_d;
  logic       v4_q, v6_q;

  assign v4_q = (fld_q.etype == ETYPE_V4);
  assign v6_q = (fld_q.etype == ETYPE_V6);

  always_comb begin
    fld_d = fld_q;
    if (valid_i) begin
      unique case (cnt_i)
        CNT_W'(12): fld_d.etype[15:8] = data_i;
        CNT_W'(13): fld_d.etype[7:0]  = data_i;
        CNT_W'(14): {fld_d.ver, fld_d.ihl} = data_i;
        CNT_W'(16): if (v4_q) fld_d.len_fld[15:8] = data_i;
        CNT_W'(17): if (v4_q) fld_d.len_fld[7:0]  = data_i;
        CNT_W'(18): if (v6_q) fld_d.len_fld[15:8] = data_i;
        CNT_W'(19): if (v6_q) fld_d.len_fld[7:0]  = data_i;
        CNT_W'(20): if (v6_q) fld_d.proto = data_i;
        CNT_W'(23): if (v4_q) fld_d.proto = data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fld_q <= '0;
    else         fld_q <= fld_d;
  end

  assign fld_o = fld_d;

  a_r2_etype_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && cnt_i > CNT_W'(13) |=> $stable(fld_q.etype));
endmodule

// File: rtl/ipchk_verdict.sv
module ipchk_verdict
  import ipchk_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  ip_fields_t       fld_i,
  output logic             sts_valid_o,
  output logic             hdr_err_o,
  output logic             pay_err_o
);
  logic [31:0] n_bytes, hlen, exp_len, got_len;
  logic        is4, is6, proto_ok, hdr_d, pay_d;

  assign n_bytes = 32'(cnt_i) + 32'd1;
  assign is4     = (fld_i.etype == ETYPE_V4);
  assign is6     = (fld_i.etype == ETYPE_V6);
  assign hlen    = is4 ? {26'd0, fld_i.ihl, 2'b00} : 32'(V6_HDR_B);
  assign exp_len = is4 ? (32'(fld_i.len_fld) - hlen) : 32'(fld_i.len_fld);
  assign got_len = n_bytes - 32'(ETH_HDR_B) - hlen;

  always_comb begin
    if (is4) proto_ok = fld_i.proto inside {8'd1, 8'd6, 8'd17};
    else     proto_ok = fld_i.proto inside {8'd6, 8'd17, 8'd58};
  end

  // ordered checks: first failing rule decides
  always_comb begin
    hdr_d = 1'b0;
    pay_d = 1'b0;
    if (n_bytes < 32'(ETH_HDR_B) || !(is4 || is6)) begin
      hdr_d = 1'b0;
    end else if (n_bytes < 32'(ETH_HDR_B) + 32'd1) begin
      hdr_d = 1'b1;
    end else if ((is4 && fld_i.ver != 4'd4) || (is6 && fld_i.ver != 4'd6)) begin
      hdr_d = 1'b1;
    end else if (is4 && fld_i.ihl < 4'd5) begin
      hdr_d = 1'b1;
    end else if (n_bytes < 32'(ETH_HDR_B) + hlen) begin
      hdr_d = 1'b1;
    end else if (!proto_ok) begin
      hdr_d = 1'b0;
    end else if (is4 && 32'(fld_i.len_fld) < hlen) begin
      hdr_d = 1'b1;
    end else begin
      pay_d = (exp_len != got_len);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_valid_o <= 1'b0;
      hdr_err_o   <= 1'b0;
      pay_err_o   <= 1'b0;
    end else if (valid_i && last_i) begin
      sts_valid_o <= 1'b1;
      hdr_err_o   <= hdr_d;
      pay_err_o   <= pay_d;
    end else if (valid_i) begin
      sts_valid_o <= 1'b0;
      hdr_err_o   <= 1'b0;
      pay_err_o   <= 1'b0;
    end
  end

  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_err_o && pay_err_o));
  a_r10_flags_need_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_valid_o |-> !hdr_err_o && !pay_err_o);
  a_r10_rise_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_valid_o) |-> $past(valid_i && last_i));
  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({sts_valid_o, hdr_err_o, pay_err_o}));
  a_r10_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !last_i && cnt_i == '0 |=> !sts_valid_o);
endmodule

// File: rtl/ipchk_top.sv
module ipchk_top
  import ipchk_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       last_i,
  output logic       sts_valid_o,
  output logic       hdr_err_o,
  output logic       pay_err_o,
  output logic       err_sum_o
);
  logic [CNT_W-1:0] cnt;
  ip_fields_t       fld;

  ipchk_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .valid_i, .last_i, .cnt_o(cnt)
  );

  ipchk_field_cap #(.CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni, .valid_i, .data_i, .cnt_i(cnt), .fld_o(fld)
  );

  ipchk_verdict #(.CNT_W(CNT_W)) u_vrd (
    .clk_i, .rst_ni, .valid_i, .last_i, .cnt_i(cnt), .fld_i(fld),
    .sts_valid_o, .hdr_err_o, .pay_err_o
  );

  assign err_sum_o = hdr_err_o | pay_err_o;

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sts_valid_o && !err_sum_o);
endmodule

// File: tb/sim_ipchk_top.sv
`timescale 1ns/1ps
module sim_ipchk_top;
  logic       clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       sts_valid_o, hdr_err_o, pay_err_o, err_sum_o;
  int         checks = 0, errors = 0;
  bit         done = 0;
  logic [7:0] fb [0:255];

  always #10 clk = ~clk;

  ipchk_top u0 (.clk_i(clk), .rst_ni, .valid_i, .data_i, .last_i,
                .sts_valid_o, .hdr_err_o, .pay_err_o, .err_sum_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {hdr, pay} from the requirements; returns tag of deciding rule
  function automatic logic [1:0] model(int n, output string tag);
    logic [15:0] et, lf;
    int hl, ex;
    bit v4, v6, ok;
    logic [7:0] pr;
    tag = "R2";
    if (n < 14) return 2'b00;
    et = {fb[12], fb[13]};
    v4 = (et == 16'h0800); v6 = (et == 16'h86DD);
    if (!(v4 || v6)) return 2'b00;
    tag = "R3";
    if (n < 15) return 2'b10;
    if ((v4 && fb[14][7:4] != 4) || (v6 && fb[14][7:4] != 6)) return 2'b10;
    tag = "R4";
    if (v4 && fb[14][3:0] < 5) return 2'b10;
    hl = v4 ? int'(fb[14][3:0]) * 4 : 40;
    tag = "R5";
    if (n < 14 + hl) return 2'b10;
    pr = v4 ? fb[23] : fb[20];
    ok = v4 ? (pr == 1 || pr == 6 || pr == 17) : (pr == 6 || pr == 17 || pr == 58);
    tag = "R7";
    if (!ok) return 2'b00;
    lf = v4 ? {fb[16], fb[17]} : {fb[18], fb[19]};
    tag = "R6";
    if (v4 && int'(lf) < hl) return 2'b10;
    tag = "R8";
    ex = v4 ? int'(lf) - hl : int'(lf);
    return {1'b0, ex != (n - 14 - hl)};
  endfunction

  function automatic int build(logic [15:0] et, logic [3:0] ver, logic [3:0] ihl,
                               logic [15:0] lf, logic [7:0] pr, int plen);
    int hl = (et == 16'h86DD) ? 40 : ((ihl < 5) ? 20 : int'(ihl) * 4);
    int n  = 14 + hl + plen;
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = {ver, ihl};
    if (et == 16'h86DD) begin
      fb[18] = lf[15:8]; fb[19] = lf[7:0]; fb[20] = pr;
    end else begin
      fb[16] = lf[15:8]; fb[17] = lf[7:0]; fb[23] = pr;
    end
    return n;
  endfunction

  task automatic send(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && i > 0 && ($urandom % 4) == 0) begin
        @(negedge clk); valid_i = 1'b0; last_i = 1'b0;
      end
      @(negedge clk);
      if (i == 1) chk("R10 cleared at frame start", sts_valid_o, 0);
      valid_i = 1'b1; data_i = fb[i]; last_i = (i == n - 1);
    end
    @(negedge clk);
    valid_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic run(int n, bit gaps);
    logic [1:0] e;
    string tag;
    e = model(n, tag);
    send(n, gaps);
    chk("R10 strobe", sts_valid_o, 1);
    chk({tag, " hdr"}, hdr_err_o, e[1]);
    chk({tag, " pay"}, pay_err_o, e[0]);
    chk("R9 sum", err_sum_o, e[1] | e[0]);
    repeat (2) @(negedge clk);
    chk("R10 hold", {sts_valid_o, hdr_err_o, pay_err_o}, {1'b1, e});
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    #5;
    chk("R1 reset", {sts_valid_o, hdr_err_o, pay_err_o, err_sum_o}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle", {sts_valid_o, err_sum_o}, 0);

    // R2: foreign ethertype and too short
    n = build(16'h0806, 4, 5, 16'd28, 6, 8);  run(n, 0);
    chk("R2 arp flags", err_sum_o, 0);
    n = build(16'h0800, 4, 5, 16'd20, 6, 0);  run(10, 0);
    n = build(16'h0800, 4, 5, 16'd20, 6, 0);  run(14, 0);   // R3 no version byte
    chk("R3 missing version", hdr_err_o, 1);
    n = build(16'h0800, 6, 5, 16'd30, 6, 10); run(n, 0);   // R3
    n = build(16'h86DD, 4, 0, 16'd8, 17, 8);  run(n, 0);   // R3
    n = build(16'h0800, 4, 4, 16'd30, 17, 10); run(n, 0);  // R4
    chk("R4 ihl 4", hdr_err_o, 1);
    n = build(16'h0800, 4, 5, 16'd20, 17, 0); run(n, 0);   // R8 zero payload ok
    chk("R8 ihl 5 empty", err_sum_o, 0);
    n = build(16'h0800, 4, 7, 16'd40, 6, 0);  run(41, 0);  // R5 one short
    chk("R5 v4 short", {hdr_err_o, pay_err_o}, 2'b10);
    n = build(16'h86DD, 6, 0, 16'd0, 6, 0);   run(53, 0);  // R5
    chk("R5 v6 short", {hdr_err_o, pay_err_o}, 2'b10);
    n = build(16'h0800, 4, 6, 16'd20, 6, 4);  run(n, 0);   // R6
    chk("R6 total below hdr", hdr_err_o, 1);
    n = build(16'h0800, 4, 5, 16'd99, 47, 3); run(n, 0);   // R7
    chk("R7 gre", err_sum_o, 0);
    n = build(16'h86DD, 6, 0, 16'd5, 1, 7);   run(n, 0);   // R7 v4 icmp code under v6
    n = build(16'h0800, 4, 5, 16'd28, 1, 8);  run(n, 0);   // R8 icmp ok
    n = build(16'h86DD, 6, 0, 16'd8, 58, 8);  run(n, 0);   // R8 icmpv6 ok
    n = build(16'h0800, 4, 6, 16'd35, 17, 10); run(n, 0);  // R8 +1
    chk("R8 v4 long field", pay_err_o, 1);
    n = build(16'h0800, 4, 6, 16'd33, 17, 10); run(n, 0);  // R8 -1
    n = build(16'h86DD, 6, 0, 16'd11, 6, 12); run(n, 1);   // R8
    chk("R8 v6 mismatch", pay_err_o, 1);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [15:0] et, lf;
      logic [3:0]  ver, ihl;
      logic [7:0]  pr;
      int pl, r, hl;
      r   = $urandom % 10;
      et  = (r < 5) ? 16'h0800 : (r < 9) ? 16'h86DD : 16'(($urandom % 2) ? 16'h0806 : 16'h88CC);
      ver = (($urandom % 8) == 0) ? 4'($urandom) : ((et == 16'h86DD) ? 4'd6 : 4'd4);
      ihl = (($urandom % 8) == 0) ? 4'($urandom % 5) : 4'(5 + $urandom % 11);
      case ($urandom % 6)
        0: pr = 8'd1; 1: pr = 8'd6; 2: pr = 8'd17; 3: pr = 8'd58;
        4: pr = 8'd6; default: pr = 8'($urandom);
      endcase
      pl  = $urandom % 48;
      hl  = (et == 16'h86DD) ? 40 : ((ihl < 5) ? 20 : int'(ihl) * 4);
      lf  = (et == 16'h86DD) ? 16'(pl) : 16'(pl + hl);
      if (($urandom % 4) == 0) lf = lf + 16'($urandom % 5) - 16'd2;
      n = build(et, ver, ihl, lf, pr, pl);
      if (($urandom % 7) == 0) n = 1 + $urandom % n;
      run(n, bit'($urandom % 2));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule